// File: doc/BRIEF.md
# Codec Port Resynchronization Sequencer

This block runs on the host side of a byte-serial codec control port. It brings the port back into step after the codec missed its power-on reset or after the host restarted while the codec was still in the middle of a multi-byte transfer. It does not drive pins itself. It hands one byte transaction at a time to a serial master over a request/acknowledge pair and reads back the byte the master returns. It also keeps a running count of the bytes it has put on the port.

In the default recovery mode the block reads the revision code and compares it with an expected value. When the code matches, it writes the clock selection, issues a software reset, writes a test timeslot value and reads that value back. A mismatch anywhere sends it back to the revision read, and every transaction still counts toward a 128-byte budget, so a stuck codec is clocked forward by the checks themselves. A restart mode recovers a codec left in a partial transfer: it pads with fourteen dummy reads and gives a single verification attempt. A write-only mode floods the port with all-ones bytes and then sends the clock selection and software reset without reading anything back.

Top module: `codec_resync_seq`

## Requirements
- R1: After reset, busy_o, done_o, fail_o, req_o and bytes_o are all zero.
- R2: A start_i pulse while idle raises busy_o, clears bytes_o and fail_o, and latches mode_i (00 = recovery, 01 = restart, 1x = write-only). A start_i pulse while busy_o is high has no effect on the transaction order or on the results.
- R3: op_o and wdata_o stay constant while req_o is high. A transaction ends on ack_i, or after TMO_CYC cycles without ack_i. A transaction that ends without ack_i counts as a mismatch, and its bytes are still counted.
- R4: In recovery mode, each revision read (op 0) adds 2 to bytes_o. When the code read equals exp_rev_i, the block issues op 1 (clock select, data CLKSEL_CODE = 8'h40), op 2 (software reset), op 3 (timeslot write, data ts_val_i) and op 4 (timeslot read), in that order. This group adds 6.
- R5: A timeslot readback equal to ts_val_i, with no transaction in the group ending without ack_i, ends the run with done_o high and fail_o low.
- R6: In recovery mode, a revision or readback mismatch returns to the revision read while bytes_o is below BUDGET (128). Otherwise the run ends with fail_o high. bytes_o never exceeds BUDGET+8.
- R7: In write-only mode, the block issues BUDGET op 5 writes with data 8'hFF, then op 1, then op 2. Each adds 1, so the final count is 130 and fail_o is low. No read is issued.
- R8: In restart mode, a revision mismatch is followed by DUMMY_RD (14) op 6 reads, each adding 1, and then the op 1 to op 4 group. A revision match goes straight to the group.
- R9: In restart mode, a failed verification issues one extra op 2 (adding 1) and then ends with fail_o high.
- R10: done_o is high for exactly one cycle, with busy_o low. fail_o and bytes_o hold their values until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted only while idle |
| mode_i | input | 2 | Run mode: 00 recovery, 01 restart, 1x write-only |
| exp_rev_i | input | DW | Expected revision code |
| ts_val_i | input | DW | Test timeslot value written and read back |
| req_o | output | 1 | Transaction request to the serial master |
| op_o | output | 3 | Transaction kind (0 rev read, 1 clk sel, 2 sw reset, 3 ts write, 4 ts read, 5 flush, 6 dummy read) |
| wdata_o | output | DW | Byte to write for write transactions |
| ack_i | input | 1 | Transaction complete from the master |
| rdata_i | input | DW | Byte read by the master, valid with ack_i |
| busy_o | output | 1 | Sequence running |
| done_o | output | 1 | One-cycle end-of-run pulse |
| fail_o | output | 1 | Run ended without verification |
| bytes_o | output | $clog2(BUDGET)+1 | Bytes sent in the current or last run |

## Verification
Two events can fall in the same cycle. One is a new start pulse arriving while a run is in flight. The other is the completion of the transaction that the run is waiting on, or the handshake of the next one. The bench raises start_i a few cycles into a recovery run, while the first revision read is still outstanding. It then checks that the queued transaction order, the final count of 8 and the success flag are exactly those of an undisturbed run. The other overlap is the budget check landing on the cycle a readback fails. The bench runs this with counts of 128 and 130, and checks that the first stops exactly at the budget and the second stops one group past it.

// File: rtl/codec_resync_pkg.sv
package codec_resync_pkg;

  typedef enum logic [2:0] {
    OP_REV_RD   = 3'd0,
    OP_CLK_WR   = 3'd1,
    OP_SRST_WR  = 3'd2,
    OP_TS_WR    = 3'd3,
    OP_TS_RD    = 3'd4,
    OP_FLUSH_WR = 3'd5,
    OP_DUMMY_RD = 3'd6
  } op_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_REV,
    ST_CLK,
    ST_SRST,
    ST_TSW,
    ST_TSR,
    ST_DECIDE,
    ST_DUMMY,
    ST_FLUSH,
    ST_EXRST
  } st_e;

  localparam int unsigned ADD_REV   = 2;
  localparam int unsigned ADD_GROUP = 6;

endpackage

// File: rtl/resync_txn_port.sv
module resync_txn_port
  import codec_resync_pkg::*;
#(
  parameter int unsigned DW      = 8,
  parameter int unsigned TMO_CYC = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          go_i,
  input  op_e           op_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          ack_i,
  input  logic [DW-1:0] rdata_i,
  output logic          req_o,
  output op_e           op_o,
  output logic [DW-1:0] wdata_o,
  output logic          fin_o,
  output logic          ok_o,
  output logic [DW-1:0] rdata_o
);

  localparam int unsigned TW = $clog2(TMO_CYC + 1);

  logic          req_q, req_d;
  op_e           op_q, op_d;
  logic [DW-1:0] wd_q, wd_d;
  logic          fin_q, fin_d;
  logic          ok_q, ok_d;
  logic [DW-1:0] rd_q, rd_d;
  logic [TW-1:0] tcnt_q, tcnt_d;

  always_comb begin
    req_d  = req_q;
    op_d   = op_q;
    wd_d   = wd_q;
    fin_d  = 1'b0;
    ok_d   = ok_q;
    rd_d   = rd_q;
    tcnt_d = tcnt_q;
    if (!req_q) begin
      if (go_i) begin
        req_d  = 1'b1;
        op_d   = op_i;
        wd_d   = wdata_i;
        tcnt_d = '0;
      end
    end else if (ack_i) begin
      req_d = 1'b0;
      fin_d = 1'b1;
      ok_d  = 1'b1;
      rd_d  = rdata_i;
    end else if (tcnt_q == TW'(TMO_CYC - 1)) begin
      req_d = 1'b0;
      fin_d = 1'b1;
      ok_d  = 1'b0;
    end else begin
      tcnt_d = tcnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= 1'b0;
      op_q   <= OP_REV_RD;
      wd_q   <= '0;
      fin_q  <= 1'b0;
      ok_q   <= 1'b0;
      rd_q   <= '0;
      tcnt_q <= '0;
    end else begin
      req_q  <= req_d;
      op_q   <= op_d;
      wd_q   <= wd_d;
      fin_q  <= fin_d;
      ok_q   <= ok_d;
      rd_q   <= rd_d;
      tcnt_q <= tcnt_d;
    end
  end

  assign req_o   = req_q;
  assign op_o    = op_q;
  assign wdata_o = wd_q;
  assign fin_o   = fin_q;
  assign ok_o    = ok_q;
  assign rdata_o = rd_q;

endmodule

// File: rtl/resync_ledger.sv
module resync_ledger #(
  parameter int unsigned BUDGET = 128,
  parameter int unsigned CW     = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          add_en_i,
  input  logic [2:0]    add_i,
  output logic [CW-1:0] cnt_o,
  output logic          under_o
);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)         cnt_d = '0;
    else if (add_en_i) cnt_d = cnt_q + CW'(add_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o   = cnt_q;
  assign under_o = (cnt_q < CW'(BUDGET));

endmodule

// File: rtl/resync_ctrl.sv
module resync_ctrl
  import codec_resync_pkg::*;
#(
  parameter int unsigned   DW          = 8,
  parameter int unsigned   DUMMY_RD    = 14,
  parameter logic [DW-1:0] CLKSEL_CODE = 8'h40
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [1:0]    mode_i,
  input  logic [DW-1:0] exp_rev_i,
  input  logic [DW-1:0] ts_val_i,
  input  logic          fin_i,
  input  logic          ok_i,
  input  logic [DW-1:0] rdata_i,
  input  logic          under_i,
  output logic          go_o,
  output op_e           op_o,
  output logic [DW-1:0] wdata_o,
  output logic          clr_o,
  output logic          add_en_o,
  output logic [2:0]    add_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          fail_o
);

  localparam int unsigned DCW = (DUMMY_RD > 1) ? $clog2(DUMMY_RD) : 1;

  st_e            st_q, st_d;
  logic           wait_q, wait_d;
  logic           warm_q, warm_d;
  logic           blind_q, blind_d;
  logic           bad_q, bad_d;
  logic [DCW-1:0] dcnt_q, dcnt_d;
  logic           done_q, done_d;
  logic           fail_q, fail_d;
  logic           op_state;

  always_comb begin
    op_state = 1'b1;
    op_o     = OP_REV_RD;
    wdata_o  = '0;
    case (st_q)
      ST_REV:   op_o = OP_REV_RD;
      ST_CLK:   begin op_o = OP_CLK_WR; wdata_o = CLKSEL_CODE; end
      ST_SRST:  op_o = OP_SRST_WR;
      ST_EXRST: op_o = OP_SRST_WR;
      ST_TSW:   begin op_o = OP_TS_WR; wdata_o = ts_val_i; end
      ST_TSR:   op_o = OP_TS_RD;
      ST_DUMMY: op_o = OP_DUMMY_RD;
      ST_FLUSH: begin op_o = OP_FLUSH_WR; wdata_o = '1; end
      default:  op_state = 1'b0;
    endcase
  end

  always_comb begin
    st_d     = st_q;
    wait_d   = wait_q;
    warm_d   = warm_q;
    blind_d  = blind_q;
    bad_d    = bad_q;
    dcnt_d   = dcnt_q;
    done_d   = 1'b0;
    fail_d   = fail_q;
    go_o     = 1'b0;
    clr_o    = 1'b0;
    add_en_o = 1'b0;
    add_o    = '0;

    if (op_state && !wait_q) begin
      if (st_q == ST_FLUSH && !under_i) begin
        st_d = ST_CLK;
      end else begin
        go_o   = 1'b1;
        wait_d = 1'b1;
      end
    end

    case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          clr_o   = 1'b1;
          fail_d  = 1'b0;
          warm_d  = (mode_i == 2'b01);
          blind_d = mode_i[1];
          wait_d  = 1'b0;
          st_d    = mode_i[1] ? ST_FLUSH : ST_REV;
        end
      end
      ST_DECIDE: begin
        if (under_i) begin
          st_d = ST_REV;
        end else begin
          st_d   = ST_IDLE;
          done_d = 1'b1;
          fail_d = 1'b1;
        end
      end
      default: begin
        if (wait_q && fin_i) begin
          wait_d = 1'b0;
          case (st_q)
            ST_REV: begin
              add_en_o = 1'b1;
              add_o    = 3'(ADD_REV);
              if (ok_i && rdata_i == exp_rev_i) begin
                bad_d = 1'b0;
                st_d  = ST_CLK;
              end else if (warm_q) begin
                dcnt_d = '0;
                st_d   = ST_DUMMY;
              end else begin
                st_d = ST_DECIDE;
              end
            end
            ST_DUMMY: begin
              add_en_o = 1'b1;
              add_o    = 3'd1;
              if (dcnt_q == DCW'(DUMMY_RD - 1)) begin
                bad_d = 1'b0;
                st_d  = ST_CLK;
              end else begin
                dcnt_d = dcnt_q + 1'b1;
              end
            end
            ST_CLK: begin
              if (blind_q) begin
                add_en_o = 1'b1;
                add_o    = 3'd1;
              end
              bad_d = bad_q | ~ok_i;
              st_d  = ST_SRST;
            end
            ST_SRST: begin
              if (blind_q) begin
                add_en_o = 1'b1;
                add_o    = 3'd1;
                st_d     = ST_IDLE;
                done_d   = 1'b1;
                fail_d   = 1'b0;
              end else begin
                bad_d = bad_q | ~ok_i;
                st_d  = ST_TSW;
              end
            end
            ST_TSW: begin
              bad_d = bad_q | ~ok_i;
              st_d  = ST_TSR;
            end
            ST_TSR: begin
              add_en_o = 1'b1;
              add_o    = 3'(ADD_GROUP);
              if (!bad_q && ok_i && rdata_i == ts_val_i) begin
                st_d   = ST_IDLE;
                done_d = 1'b1;
                fail_d = 1'b0;
              end else if (warm_q) begin
                st_d = ST_EXRST;
              end else begin
                st_d = ST_DECIDE;
              end
            end
            ST_FLUSH: begin
              add_en_o = 1'b1;
              add_o    = 3'd1;
            end
            ST_EXRST: begin
              add_en_o = 1'b1;
              add_o    = 3'd1;
              st_d     = ST_IDLE;
              done_d   = 1'b1;
              fail_d   = 1'b1;
            end
            default: st_d = ST_IDLE;
          endcase
        end
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      wait_q  <= 1'b0;
      warm_q  <= 1'b0;
      blind_q <= 1'b0;
      bad_q   <= 1'b0;
      dcnt_q  <= '0;
      done_q  <= 1'b0;
      fail_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      wait_q  <= wait_d;
      warm_q  <= warm_d;
      blind_q <= blind_d;
      bad_q   <= bad_d;
      dcnt_q  <= dcnt_d;
      done_q  <= done_d;
      fail_q  <= fail_d;
    end
  end

  assign busy_o = (st_q != ST_IDLE);
  assign done_o = done_q;
  assign fail_o = fail_q;

endmodule

// File: rtl/codec_resync_seq.sv
module codec_resync_seq
  import codec_resync_pkg::*;
#(
  parameter int unsigned   DW          = 8,
  parameter int unsigned   BUDGET      = 128,
  parameter int unsigned   DUMMY_RD    = 14,
  parameter int unsigned   TMO_CYC     = 32,
  parameter logic [DW-1:0] CLKSEL_CODE = 8'h40
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic [1:0]               mode_i,
  input  logic [DW-1:0]            exp_rev_i,
  input  logic [DW-1:0]            ts_val_i,
  output logic                     req_o,
  output logic [2:0]               op_o,
  output logic [DW-1:0]            wdata_o,
  input  logic                     ack_i,
  input  logic [DW-1:0]            rdata_i,
  output logic                     busy_o,
  output logic                     done_o,
  output logic                     fail_o,
  output logic [$clog2(BUDGET):0]  bytes_o
);

  localparam int unsigned CW = $clog2(BUDGET) + 1;

  logic          go;
  op_e           ctl_op;
  logic [DW-1:0] ctl_wd;
  logic          fin, ok;
  logic [DW-1:0] rd;
  logic          clr, add_en, under;
  logic [2:0]    add;
  op_e           port_op;

  resync_ctrl #(
    .DW(DW), .DUMMY_RD(DUMMY_RD), .CLKSEL_CODE(CLKSEL_CODE)
  ) ctrl_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .mode_i(mode_i),
    .exp_rev_i(exp_rev_i), .ts_val_i(ts_val_i), .fin_i(fin), .ok_i(ok),
    .rdata_i(rd), .under_i(under), .go_o(go), .op_o(ctl_op),
    .wdata_o(ctl_wd), .clr_o(clr), .add_en_o(add_en), .add_o(add),
    .busy_o(busy_o), .done_o(done_o), .fail_o(fail_o)
  );

  resync_txn_port #(.DW(DW), .TMO_CYC(TMO_CYC)) port_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .go_i(go), .op_i(ctl_op),
    .wdata_i(ctl_wd), .ack_i(ack_i), .rdata_i(rdata_i), .req_o(req_o),
    .op_o(port_op), .wdata_o(wdata_o), .fin_o(fin), .ok_o(ok), .rdata_o(rd)
  );

  resync_ledger #(.BUDGET(BUDGET), .CW(CW)) ledger_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr), .add_en_i(add_en),
    .add_i(add), .cnt_o(bytes_o), .under_o(under)
  );

  assign op_o = port_op;

endmodule

// File: rtl/codec_resync_chk.sv
module codec_resync_chk #(
  parameter int unsigned DW     = 8,
  parameter int unsigned BUDGET = 128
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    req_o,
  input logic [2:0]              op_o,
  input logic [DW-1:0]           wdata_o,
  input logic                    busy_o,
  input logic                    done_o,
  input logic                    fail_o,
  input logic [$clog2(BUDGET):0] bytes_o
);

  localparam int unsigned CW = $clog2(BUDGET) + 1;

  p_req_in_run_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> busy_o);

  p_req_steady_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && $past(req_o)) |-> ($stable(op_o) && $stable(wdata_o)));

  p_start_clears_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> (bytes_o == '0));

  p_done_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  p_done_single_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_idle_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && $past(!busy_o)) |-> ($stable(fail_o) && $stable(bytes_o)));

  p_fail_at_end_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fail_o) |-> done_o);

  p_count_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bytes_o <= CW'(BUDGET + 8));

  p_flush_ones_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && op_o == 3'd5) |-> (wdata_o == '1));

endmodule

bind codec_resync_seq codec_resync_chk #(.DW(DW), .BUDGET(BUDGET)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_o(req_o), .op_o(op_o),
  .wdata_o(wdata_o), .busy_o(busy_o), .done_o(done_o), .fail_o(fail_o),
  .bytes_o(bytes_o)
);

// File: tb/codec_resync_seq_tb_top.sv
module codec_resync_seq_tb_top;

  localparam logic [7:0] REV = 8'hA7;
  localparam logic [7:0] TS  = 8'h3C;
  localparam logic [7:0] CKS = 8'h40;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [1:0] mode = 2'b00;
  logic       req, ack = 1'b0;
  logic [2:0] op;
  logic [7:0] wdata, rdata = 8'h00;
  logic       busy, done, fail;
  logic [7:0] bytes;

  always #4 clk = ~clk;

  codec_resync_seq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode),
    .exp_rev_i(REV), .ts_val_i(TS), .req_o(req), .op_o(op),
    .wdata_o(wdata), .ack_i(ack), .rdata_i(rdata), .busy_o(busy),
    .done_o(done), .fail_o(fail), .bytes_o(bytes)
  );

  int total = 0;
  int bad   = 0;
  int cyc   = 0;

  // master model controls
  int rev_bad_n   = 0;
  bit rev_all_bad = 0;
  bit ts_bad      = 0;
  int drop_n      = 0;
  bit dropping    = 0;
  int lat         = 1;
  int wait_c      = 0;

  logic [10:0] expq[$];

  task automatic check(input bit cond, input string rq, input string what,
                       input int act, input int exp);
    total++;
    if (!cond) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  task automatic push(input logic [2:0] o, input logic [7:0] d);
    expq.push_back({o, d});
  endtask

  task automatic push_group();
    push(3'd1, CKS); push(3'd2, 8'h00); push(3'd3, TS); push(3'd4, 8'h00);
  endtask

  // master: answers requests at negedge
  always @(negedge clk) begin
    if (ack) begin
      ack = 1'b0;
    end else if (req) begin
      if (!dropping && drop_n > 0) dropping = 1'b1;
      if (!dropping) begin
        wait_c++;
        if (wait_c >= lat) begin
          wait_c = 0;
          rdata = 8'h00;
          if (op == 3'd0) begin
            if (rev_all_bad) rdata = REV ^ 8'h5A;
            else if (rev_bad_n > 0) begin rev_bad_n--; rdata = REV ^ 8'h5A; end
            else rdata = REV;
          end else if (op == 3'd4) begin
            rdata = ts_bad ? ~TS : TS;
          end
          ack = 1'b1;
        end
      end
    end else if (dropping) begin
      dropping = 1'b0;
      drop_n--;
    end
  end

  // scoreboard monitor: every acknowledged transaction against the queue
  always @(posedge ack) begin
    logic [10:0] e;
    if (expq.size() == 0) begin
      check(1'b0, "R3", "unexpected transaction op", int'(op), -1);
    end else begin
      e = expq.pop_front();
      check(op == e[10:8], "R4", "transaction op", int'(op), int'(e[10:8]));
      if (op == 3'd1 || op == 3'd3 || op == 3'd5)
        check(wdata == e[7:0], "R4", "write data", int'(wdata), int'(e[7:0]));
    end
  end

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        check(1'b0, "WD", "watchdog cycles", cyc, 150000);
        finish_run();
      end
    end
  end

  task automatic run(input logic [1:0] m, input int exp_bytes, input bit exp_fail,
                     input string rq, input bit restart_mid);
    int n;
    logic [7:0] b;
    logic f;
    @(negedge clk);
    mode = m; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (restart_mid) begin
      repeat (2) @(negedge clk);
      mode = 2'b10; start = 1'b1;   // R2: must be ignored while busy
      @(negedge clk);
      start = 1'b0;
    end
    n = 0;
    while (!done && n < 20000) begin @(negedge clk); n++; end
    check(done == 1'b1, rq, "done reached", int'(done), 1);
    check(busy == 1'b0, "R10", "busy low with done", int'(busy), 0);
    check(bytes == 8'(exp_bytes), rq, "bytes sent", int'(bytes), exp_bytes);
    check(fail == exp_fail, rq, "fail flag", int'(fail), int'(exp_fail));
    check(expq.size() == 0, rq, "queued transactions left", expq.size(), 0);
    b = bytes; f = fail;
    @(negedge clk);
    check(done == 1'b0, "R10", "done width", int'(done), 0);
    repeat (3) @(negedge clk);
    check(bytes == b && fail == f, "R10", "results held", int'(bytes), int'(b));
    expq.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(busy == 0 && done == 0 && fail == 0 && req == 0 && bytes == 0,
          "R1", "reset outputs", int'({busy, done, fail, req}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(busy == 0 && bytes == 0, "R1", "idle after release", int'(bytes), 0);

    // R4 R5: clean recovery
    push(3'd0, 0); push_group();
    run(2'b00, 8, 0, "R5", 0);

    // R2: start while busy ignored
    push(3'd0, 0); push_group();
    run(2'b00, 8, 0, "R2", 1);

    // R4 R6: two revision misses then success
    rev_bad_n = 2;
    repeat (3) push(3'd0, 0);
    push_group();
    run(2'b00, 12, 0, "R6", 0);

    // R6: revision never matches, 64 reads, stops at budget
    rev_all_bad = 1;
    repeat (64) push(3'd0, 0);
    run(2'b00, 128, 1, "R6", 0);
    rev_all_bad = 0;

    // R6: readback always wrong, 16 groups
    ts_bad = 1;
    repeat (16) begin push(3'd0, 0); push_group(); end
    run(2'b00, 128, 1, "R6", 0);

    // R6: one revision miss then readback wrong, stops at 130
    rev_bad_n = 1;
    push(3'd0, 0);
    repeat (16) begin push(3'd0, 0); push_group(); end
    run(2'b00, 130, 1, "R6", 0);
    ts_bad = 0;

    // R3: first revision read times out, counts as a miss
    drop_n = 1; lat = 3;
    push(3'd0, 0); push_group();
    run(2'b00, 10, 0, "R3", 0);
    lat = 1;

    // R7: write-only flush
    repeat (128) push(3'd5, 8'hFF);
    push(3'd1, CKS); push(3'd2, 8'h00);
    run(2'b10, 130, 0, "R7", 0);

    // R8: restart mode, revision matches
    push(3'd0, 0); push_group();
    run(2'b01, 8, 0, "R8", 0);

    // R8 R9: restart mode, revision and readback wrong
    rev_all_bad = 1; ts_bad = 1;
    push(3'd0, 0);
    repeat (14) push(3'd6, 8'h00);
    push_group();
    push(3'd2, 8'h00);
    run(2'b01, 23, 1, "R9", 0);
    rev_all_bad = 0; ts_bad = 0;

    // R8: restart mode, revision wrong, verify passes
    rev_bad_n = 1;
    push(3'd0, 0);
    repeat (14) push(3'd6, 8'h00);
    push_group();
    run(2'b01, 22, 0, "R8", 0);

    finish_run();
  end

endmodule